// File: doc/BRIEF.md
# Calendar Real-Time Counter

This block keeps wall-clock calendar time in hardware. A prescaler divides the system clock down to a one-second tick. Each tick advances a chain of counters for second, minute, hour, day of month, day of week, day of year, month and a 12-bit year. The day of month follows the length of the current month, including Gregorian leap years. Software reaches the block through a small word-addressed register port. Every calendar field can be written on its own. Three read-only packed words return a consistent snapshot of all fields.

A per-field enable mask selects which field increments raise a sticky interrupt flag. The flag stays set until software clears it. A control register starts and stops counting and can hold the prescaler in reset. This lets software set the time and then release the counter at a known point in the second.

Top module: `cal_rtc`

## Requirements
- R1: After reset, second, minute, hour, day of week, day of year, month and year read 0, day of month reads 1, the interrupt output is low, and the control and enable registers read 0.
- R2: While control bit 0 (address 1) is set and bit 1 is clear, the seconds counter advances once every PRESCALE clock cycles. While bit 0 is clear, no field changes.
- R3: While control bit 1 is set, the prescaler is held at zero and nothing counts. After bit 1 clears with bit 0 set, the first tick lands exactly PRESCALE cycles later.
- R4: Seconds and minutes count 0 to 59, hours 0 to 23 and day of week 0 to 6. Each field wraps to 0 and carries to the next field on the same tick.
- R5: Months count 0 to 11 and day of month runs from 1 to the month length. Month 1 has 29 days when the year is divisible by 4 but not by 100, or divisible by 400, and 28 days otherwise. Months 3, 5, 8 and 10 have 30 days and all others have 31.
- R6: Day of year increments with every day and returns to 0 when the year increments. The year wraps from 4095 to 0.
- R7: All fields affected by one tick change on the same clock edge, so the three packed words read back-to-back between ticks describe the same instant.
- R8: Packed word 0 (address 3) holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day of week in [26:24]. Word 1 (address 4) holds day of month in [4:0], month in [11:8] and year in [27:16]. Word 2 (address 5) holds day of year in [11:0]. All other bits read 0.
- R9: Addresses 8 to 15 read and write the second, minute, hour, day-of-month, day-of-week, day-of-year, month and year counters in that order. A counter write never causes a carry into another field.
- R10: When a counter write and a tick fall on the same edge, the written field takes the written value. The other fields still advance as the tick's carries from the old values dictate.
- R11: The enable register (address 2) has bit 0 for seconds, 1 for minutes, 2 for hours, 3 for day of month, 4 for day of week, 5 for day of year, 6 for month and 7 for year. The flag sets when any enabled field increments. Increments of disabled fields leave it clear.
- R12: The flag drives the interrupt output and reads at address 0 bit 0. It stays set until a write of 1 to that bit, or a write of 0 to the enable register, clears it. A new enabled increment on the same edge wins over the clear.
- R13: Control bits 0, 1 and 4 read back as written. Bit 4 has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 4 | Word address for reads and writes |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Sticky field-increment interrupt |

## Verification
A software counter write and a prescaler tick can land on the same clock edge. The bench provokes this by resynchronising the prescaler through the hold bit, counting PRESCALE minus one cycles, and placing a seconds write on the tick edge while seconds sit at 59. The result is judged by the written seconds value surviving while the minute still advances. The second same-edge case, an enabled increment against a flag clear, is watched by an assertion that the set wins.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int NUM_FIELDS = 8;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DOM  = 3'd3,
    F_DOW  = 3'd4,
    F_DOY  = 3'd5,
    F_MON  = 3'd6,
    F_YEAR = 3'd7
  } field_e;

  typedef enum logic [3:0] {
    A_FLAG = 4'd0,
    A_CTRL = 4'd1,
    A_IEN  = 4'd2,
    A_PK0  = 4'd3,
    A_PK1  = 4'd4,
    A_PK2  = 4'd5,
    A_SEC  = 4'd8,
    A_MIN  = 4'd9,
    A_HOUR = 4'd10,
    A_DOM  = 4'd11,
    A_DOW  = 4'd12,
    A_DOY  = 4'd13,
    A_MON  = 4'd14,
    A_YEAR = 4'd15
  } addr_e;

  typedef struct packed {
    logic [11:0] year;
    logic [3:0]  mon;
    logic [11:0] doy;
    logic [2:0]  dow;
    logic [4:0]  dom;
    logic [4:0]  hour;
    logic [5:0]  min;
    logic [5:0]  sec;
  } cal_t;

  localparam logic [5:0]  SEC_LAST  = 6'd59;
  localparam logic [5:0]  MIN_LAST  = 6'd59;
  localparam logic [4:0]  HOUR_LAST = 5'd23;
  localparam logic [2:0]  DOW_LAST  = 3'd6;
  localparam logic [3:0]  MON_LAST  = 4'd11;

  function automatic logic is_leap(input logic [11:0] yr);
    return ((yr[1:0] == 2'b00) && ((yr % 12'd100) != 12'd0)) || ((yr % 12'd400) == 12'd0);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [11:0] yr);
    case (mon)
      4'd1:                      return is_leap(yr) ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_rtc_prescale.sv
module cal_rtc_prescale #(
  parameter int PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && !hold_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (hold_i)       cnt_q <= '0;
    else if (tick_o)       cnt_q <= '0;
    else if (en_i)         cnt_q <= cnt_q + 1'b1;
  end

  // R3: hold parks the divider at zero
  p_hold_parks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));

  // R2: a stopped divider keeps its count
  p_stop_freezes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hold_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cal_rtc_counters.sv
module cal_rtc_counters
  import cal_rtc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  field_e                wr_field_i,
  input  logic [11:0]           wr_val_i,
  output cal_t                  cal_o,
  output logic [NUM_FIELDS-1:0] inc_o
);
  cal_t q, d;
  logic [4:0] mlen;
  logic c_min, c_hour, c_day, c_mon, c_year;

  assign mlen   = month_len(q.mon, q.year);
  assign c_min  = tick_i && (q.sec  >= SEC_LAST);
  assign c_hour = c_min  && (q.min  >= MIN_LAST);
  assign c_day  = c_hour && (q.hour >= HOUR_LAST);
  assign c_mon  = c_day  && (q.dom  >= mlen);
  assign c_year = c_mon  && (q.mon  >= MON_LAST);

  always_comb begin
    d = q;
    if (tick_i) d.sec  = c_min  ? 6'd0 : q.sec + 6'd1;
    if (c_min)  d.min  = c_hour ? 6'd0 : q.min + 6'd1;
    if (c_hour) d.hour = c_day  ? 5'd0 : q.hour + 5'd1;
    if (c_day) begin
      d.dom = c_mon ? 5'd1 : q.dom + 5'd1;
      d.dow = (q.dow >= DOW_LAST) ? 3'd0 : q.dow + 3'd1;
      d.doy = c_year ? 12'd0 : q.doy + 12'd1;
    end
    if (c_mon)  d.mon  = c_year ? 4'd0 : q.mon + 4'd1;
    if (c_year) d.year = q.year + 12'd1;
    // software write overrides only the addressed field
    if (wr_en_i) begin
      case (wr_field_i)
        F_SEC:  d.sec  = wr_val_i[5:0];
        F_MIN:  d.min  = wr_val_i[5:0];
        F_HOUR: d.hour = wr_val_i[4:0];
        F_DOM:  d.dom  = wr_val_i[4:0];
        F_DOW:  d.dow  = wr_val_i[2:0];
        F_DOY:  d.doy  = wr_val_i[11:0];
        F_MON:  d.mon  = wr_val_i[3:0];
        default: d.year = wr_val_i[11:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      q.dom  <= 5'd1;
    end else begin
      q <= d;
    end
  end

  assign cal_o = q;
  assign inc_o = {c_year, c_mon, c_day, c_day, c_day, c_hour, c_min, tick_i};

  // R4: second rollover carries into minute on the same edge
  p_sec_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && q.sec == 6'd59 && q.min < 6'd59)
    |=> (q.sec == 6'd0 && q.min == $past(q.min) + 6'd1));

  // R2: no tick and no write leaves every field alone
  p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(q));

  // R9: a seconds write lands without touching minutes
  p_wr_no_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !tick_i && wr_field_i == F_SEC)
    |=> (q.sec == $past(wr_val_i[5:0]) && $stable(q.min)));

  // R5: leap-year February reaches day 29
  p_leap_feb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && q.mon == 4'd1 && q.dom == 5'd28 && q.hour == 5'd23
     && q.min == 6'd59 && q.sec == 6'd59 && is_leap(q.year))
    |=> (q.dom == 5'd29 && q.mon == 4'd1));

  // R6: year rollover clears day of year
  p_doy_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && q.mon == 4'd11 && q.dom == 5'd31 && q.hour == 5'd23
     && q.min == 6'd59 && q.sec == 6'd59)
    |=> (q.doy == 12'd0 && q.mon == 4'd0 && q.dom == 5'd1));

endmodule

// File: rtl/cal_rtc_irq.sv
module cal_rtc_irq
  import cal_rtc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FIELDS-1:0] inc_i,
  input  logic                  ien_we_i,
  input  logic [NUM_FIELDS-1:0] ien_wdata_i,
  input  logic                  clr_i,
  output logic [NUM_FIELDS-1:0] ien_o,
  output logic                  flag_o
);
  logic [NUM_FIELDS-1:0] ien_q;
  logic flag_q, set_w, clr_w;

  assign set_w = |(inc_i & ien_q);
  assign clr_w = clr_i || (ien_we_i && (ien_wdata_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ien_we_i) ien_q <= ien_wdata_i;
      if (set_w)      flag_q <= 1'b1;
      else if (clr_w) flag_q <= 1'b0;
    end
  end

  assign ien_o  = ien_q;
  assign flag_o = flag_q;

  // R11: an enabled increment always raises the flag
  p_flag_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(inc_i & ien_q)) |=> flag_q);

  // R12: flag is sticky without a clear
  p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i && !ien_we_i) |=> flag_q);

  // R12: clear without a competing event drops the flag
  p_flag_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|(inc_i & ien_q))) |=> !flag_q);

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  localparam int CTRL_EN   = 0;
  localparam int CTRL_HOLD = 1;
  localparam int CTRL_CAL  = 4;

  addr_e addr;
  logic ctl_en_q, ctl_hold_q, ctl_cal_q;
  logic tick;
  logic cnt_we, ien_we, flag_clr;
  cal_t cal;
  logic [NUM_FIELDS-1:0] inc, ien;
  logic flag;
  logic unused_wdata;

  assign addr         = addr_e'(bus_addr_i);
  assign cnt_we       = bus_we_i && bus_addr_i[3];
  assign ien_we       = bus_we_i && (addr == A_IEN);
  assign flag_clr     = bus_we_i && (addr == A_FLAG) && bus_wdata_i[0];
  assign unused_wdata = ^bus_wdata_i[31:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_en_q   <= 1'b0;
      ctl_hold_q <= 1'b0;
      ctl_cal_q  <= 1'b0;
    end else if (bus_we_i && addr == A_CTRL) begin
      ctl_en_q   <= bus_wdata_i[CTRL_EN];
      ctl_hold_q <= bus_wdata_i[CTRL_HOLD];
      ctl_cal_q  <= bus_wdata_i[CTRL_CAL];
    end
  end

  cal_rtc_prescale #(.PRESCALE(PRESCALE)) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl_en_q),
    .hold_i (ctl_hold_q),
    .tick_o (tick)
  );

  cal_rtc_counters u_counters (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wr_en_i    (cnt_we),
    .wr_field_i (field_e'(bus_addr_i[2:0])),
    .wr_val_i   (bus_wdata_i[11:0]),
    .cal_o      (cal),
    .inc_o      (inc)
  );

  cal_rtc_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (inc),
    .ien_we_i    (ien_we),
    .ien_wdata_i (bus_wdata_i[NUM_FIELDS-1:0]),
    .clr_i       (flag_clr),
    .ien_o       (ien),
    .flag_o      (flag)
  );

  assign irq_o = flag;

  always_comb begin
    bus_rdata_o = '0;
    case (addr)
      A_FLAG: bus_rdata_o[0] = flag;
      A_CTRL: begin
        bus_rdata_o[CTRL_EN]   = ctl_en_q;
        bus_rdata_o[CTRL_HOLD] = ctl_hold_q;
        bus_rdata_o[CTRL_CAL]  = ctl_cal_q;
      end
      A_IEN:  bus_rdata_o[NUM_FIELDS-1:0] = ien;
      A_PK0:  bus_rdata_o = {5'b0, cal.dow, 3'b0, cal.hour, 2'b0, cal.min, 2'b0, cal.sec};
      A_PK1:  bus_rdata_o = {4'b0, cal.year, 4'b0, cal.mon, 3'b0, cal.dom};
      A_PK2:  bus_rdata_o = {20'b0, cal.doy};
      A_SEC:  bus_rdata_o = {26'b0, cal.sec};
      A_MIN:  bus_rdata_o = {26'b0, cal.min};
      A_HOUR: bus_rdata_o = {27'b0, cal.hour};
      A_DOM:  bus_rdata_o = {27'b0, cal.dom};
      A_DOW:  bus_rdata_o = {29'b0, cal.dow};
      A_DOY:  bus_rdata_o = {20'b0, cal.doy};
      A_MON:  bus_rdata_o = {28'b0, cal.mon};
      A_YEAR: bus_rdata_o = {20'b0, cal.year};
      default: bus_rdata_o = '0;
    endcase
  end

  // R2: counting disabled freezes the calendar absent writes
  p_disabled_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_en_q && !cnt_we) |=> $stable(cal));

  // R12: interrupt pin mirrors the flag read path
  p_irq_pin_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !flag_clr && !ien_we) |=> irq_o);

endmodule

// File: tb/cal_rtc_tb_top.sv
module cal_rtc_tb_top;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  int e_sec, e_min, e_hour, e_dom, e_dow, e_doy, e_mon, e_year;

  always #10 clk = ~clk;

  cal_rtc #(.PRESCALE(PS)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (bus_addr),
    .bus_we_i    (bus_we),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  function automatic bit b_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int b_mlen(int m, int y);
    if (m == 1) return b_leap(y) ? 29 : 28;
    if (m == 3 || m == 5 || m == 8 || m == 10) return 30;
    return 31;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic model_step();
    e_sec++;
    if (e_sec == 60) begin
      e_sec = 0; e_min++;
      if (e_min == 60) begin
        e_min = 0; e_hour++;
        if (e_hour == 24) begin
          e_hour = 0;
          e_dow = (e_dow + 1) % 7;
          if (e_dom == b_mlen(e_mon, e_year)) begin
            e_dom = 1; e_mon++;
            if (e_mon == 12) begin
              e_mon = 0; e_doy = 0; e_year = (e_year + 1) % 4096;
            end else e_doy++;
          end else begin
            e_dom++; e_doy++;
          end
        end
      end
    end
  endtask

  task automatic set_time(int s, int mi, int h, int dm, int dw, int dy, int mo, int y);
    wr(4'd8, s);   wr(4'd9, mi);  wr(4'd10, h); wr(4'd11, dm);
    wr(4'd12, dw); wr(4'd13, dy); wr(4'd14, mo); wr(4'd15, y);
    e_sec = s; e_min = mi; e_hour = h; e_dom = dm;
    e_dow = dw; e_doy = dy; e_mon = mo; e_year = y;
  endtask

  task automatic check_time(string req);
    logic [31:0] w0, w1, w2;
    rd(4'd3, w0); rd(4'd4, w1); rd(4'd5, w2);
    chk(req, w0, (e_dow << 24) | (e_hour << 16) | (e_min << 8) | e_sec);
    chk(req, w1, (e_year << 16) | (e_mon << 8) | e_dom);
    chk(req, w2, e_doy);
  endtask

  // leaves the prescaler freshly released, at the negedge after the release edge
  task automatic sync_start();
    wr(4'd1, 32'h3);
    wr(4'd1, 32'h1);
  endtask

  task automatic run_secs(int n);
    sync_start();
    repeat (PS * n) @(negedge clk);
    wr(4'd1, 32'h0);
    for (int i = 0; i < n; i++) model_step();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    e_sec = 0; e_min = 0; e_hour = 0; e_dom = 1; e_dow = 0; e_doy = 0; e_mon = 0; e_year = 0;
    check_time("R1");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'd1, r); chk("R1 ctrl", r, 32'h0);
    rd(4'd2, r); chk("R1 ien", r, 32'h0);

    // R9 per-field readback and write isolation
    set_time(59, 5, 7, 12, 3, 200, 6, 2001);
    rd(4'd8, r);  chk("R9 sec", r, 59);
    rd(4'd9, r);  chk("R9 min", r, 5);
    rd(4'd10, r); chk("R9 hour", r, 7);
    rd(4'd11, r); chk("R9 dom", r, 12);
    rd(4'd12, r); chk("R9 dow", r, 3);
    rd(4'd13, r); chk("R9 doy", r, 200);
    rd(4'd14, r); chk("R9 mon", r, 6);
    rd(4'd15, r); chk("R9 year", r, 2001);
    wr(4'd8, 0); e_sec = 0;
    check_time("R9 no carry on write");
    check_time("R8 packed layout");

    // R2 stopped counter holds
    repeat (20) @(negedge clk);
    check_time("R2 frozen");

    // R13 bit 4 readback, no counting
    wr(4'd1, 32'h10);
    rd(4'd1, r); chk("R13 ctrl", r, 32'h10);
    repeat (12) @(negedge clk);
    check_time("R13 no effect");
    wr(4'd1, 32'h0);

    // R3 hold keeps everything still
    wr(4'd1, 32'h3);
    rd(4'd1, r); chk("R3 ctrl", r, 32'h3);
    repeat (30) @(negedge clk);
    check_time("R3 held");

    // R2/R3 tick placement after release
    set_time(10, 0, 0, 1, 0, 0, 0, 100);
    sync_start();
    repeat (PS - 1) @(negedge clk);
    check_time("R3 before first tick");
    @(negedge clk);
    model_step();
    check_time("R3 first tick");
    repeat (PS - 1) @(negedge clk);
    check_time("R2 mid period");
    @(negedge clk);
    model_step();
    check_time("R2 second tick");
    wr(4'd1, 32'h0);

    // R4 minute and hour carries
    set_time(58, 58, 0, 5, 2, 4, 0, 300);
    run_secs(63);
    check_time("R4 carry");
    set_time(59, 59, 23, 10, 6, 9, 0, 300);
    run_secs(1);
    check_time("R4 dow wrap");

    // R5 every month end, leap and common year
    for (int y = 2023; y <= 2024; y++) begin
      for (int m = 0; m < 12; m++) begin
        set_time(59, 59, 23, b_mlen(m, y), m % 7, 100 + m, m, y);
        run_secs(1);
        check_time("R5 month end");
      end
    end
    set_time(59, 59, 23, 28, 0, 58, 1, 1900);
    run_secs(1); check_time("R5 century not leap");
    set_time(59, 59, 23, 28, 0, 58, 1, 2000);
    run_secs(1); check_time("R5 quad century leap");
    run_secs(86400 / 86400); check_time("R5 day 29 holds");

    // R6 year rollover and 12-bit wrap
    set_time(58, 59, 23, 31, 4, 364, 11, 1999);
    run_secs(3); check_time("R6 year roll");
    set_time(59, 59, 23, 31, 1, 365, 11, 4095);
    run_secs(1); check_time("R6 year wrap");

    // R7 snapshot: all fields move on one tick
    set_time(59, 59, 23, 31, 5, 364, 11, 2010);
    sync_start();
    repeat (PS) @(negedge clk);
    model_step();
    check_time("R7 same edge");
    wr(4'd1, 32'h0);

    // R10 write and tick on the same edge
    set_time(59, 3, 1, 2, 2, 1, 0, 50);
    sync_start();
    repeat (PS - 1) @(negedge clk);
    bus_addr = 4'd8; bus_wdata = 32'd20; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    wr(4'd1, 32'h0);
    e_sec = 20; e_min = 4;
    check_time("R10 write wins, minute carries");

    // R11 enable mask
    set_time(58, 0, 0, 1, 0, 0, 0, 20);
    wr(4'd2, 32'h02);
    rd(4'd2, r); chk("R11 ien", r, 32'h02);
    run_secs(1);
    chk("R11 seconds masked", {31'b0, irq}, 32'h0);
    run_secs(1);
    chk("R11 minute event", {31'b0, irq}, 32'h1);
    rd(4'd0, r); chk("R12 flag read", r, 32'h1);
    repeat (10) @(negedge clk);
    chk("R12 sticky", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h1);
    chk("R12 w1c", {31'b0, irq}, 32'h0);

    wr(4'd2, 32'h04);
    set_time(59, 58, 0, 1, 0, 0, 0, 20);
    run_secs(1);
    chk("R11 hour only, minute ignored", {31'b0, irq}, 32'h0);
    set_time(59, 59, 0, 1, 0, 0, 0, 20);
    run_secs(1);
    chk("R11 hour event", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h0);
    chk("R12 mask zero clears", {31'b0, irq}, 32'h0);
    rd(4'd0, r); chk("R12 flag clear", r, 32'h0);

    wr(4'd2, 32'h80);
    set_time(59, 59, 23, 31, 0, 364, 11, 5);
    run_secs(1);
    chk("R11 year event", {31'b0, irq}, 32'h1);
    check_time("R11 year time");
    wr(4'd0, 32'h1);
    chk("R12 cleared", {31'b0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule